// File: doc/BRIEF.md
# Bit-Field Extract Unit

This unit pulls a run of consecutive bits out of 32-bit operands for a processor datapath. In the two single-operand modes it selects a field of `fieldWidth` bits that begins at bit `fieldPos` of `srcA` and moves right-justified into the result. The upper bits are then either copies of the field's top bit or zeros. In the pair mode it treats `srcA` and `srcB` as one 64-bit value, with `srcA` as the upper half, and returns a 32-bit window of it. The window is the low half `srcB` shifted down by `fieldPos`, joined by the bits of `srcA` that enter from above at position `32 - fieldPos`.

A request is presented with `inValid`. With the output register enabled (the default), the answer and `outValid` appear one clock later. The result register loads only on a valid request and holds its value otherwise. Decode, register file access and writeback belong to the surrounding pipeline.

Top module: `bitfield_extract`

## Requirements
- R1: While `rstN` is low and after its release, before any request, `outValid` is 0 and `outResult` is 0.
- R2: With `opSel` = 2'b01 (zero-fill mode), `outResult[i]` equals `srcA[fieldPos+i]` for every i below `fieldWidth`, and all higher result bits are 0.
- R3: With `opSel` = 2'b00 (sign-fill mode), the low `fieldWidth` result bits are as in R2, and every higher result bit equals the field's top bit, `srcA[fieldPos+fieldWidth-1]`.
- R4: A `fieldWidth` of 0 gives a result of 0 in both single-operand modes, whatever `srcA` holds.
- R5: When `fieldPos + fieldWidth` exceeds 32, the field positions above bit 31 of `srcA` read as 0, and in sign-fill mode the fill bit is therefore 0.
- R6: With `opSel` = 2'b10 (pair mode), `outResult[i]` equals bit `fieldPos+i` of the 64-bit value {`srcA`,`srcB`}, so `fieldPos` = 0 returns `srcB` unchanged.
- R7: With `opSel` = 2'b11 (reserved), the result is 0.
- R8: `outValid` is high in exactly the cycles that follow a cycle in which `inValid` was high, and the result of that request is on `outResult` in the same cycle.
- R9: A cycle with `inValid` low leaves `outResult` unchanged, whatever values the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| opSel | input | 2 | Mode: 00 sign-fill, 01 zero-fill, 10 pair, 11 reserved |
| srcA | input | 32 | Field source; upper half in pair mode |
| srcB | input | 32 | Lower half in pair mode |
| fieldPos | input | 5 | Field start bit, or window shift in pair mode |
| fieldWidth | input | 5 | Field length in bits (0 to 31) |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outResult | output | 32 | Extracted value |

## Verification
The clocked properties assume that `opSel`, `fieldPos`, `fieldWidth` and both operands carry defined values in every cycle where `inValid` is high. They also assume that `inValid` itself is never unknown once reset has been released. The bench changes all inputs only on the falling clock edge. It sets every field to a known value before it first raises `inValid`, and afterwards it only ever replaces those values with other defined patterns. Between requests the bench keeps `inValid` low. While it is low, the bench deliberately changes the data inputs to show that the result register holds its value.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  typedef enum logic [1:0] {
    OP_SIGN_FILL = 2'b00,
    OP_ZERO_FILL = 2'b01,
    OP_PAIR      = 2'b10,
    OP_RESERVED  = 2'b11
  } bfxOp_e;

  // Strobes from control to datapath / output stage
  typedef struct packed {
    logic selSign;
    logic selZero;
    logic selPair;
    logic capture;
  } bfxStrobes_t;

endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opSel,
  output bfxStrobes_t strobes,
  output logic        validOut
);

  always_comb begin
    strobes         = '0;
    strobes.capture = inValid;
    case (bfxOp_e'(opSel))
      OP_SIGN_FILL: strobes.selSign = 1'b1;
      OP_ZERO_FILL: strobes.selZero = 1'b1;
      OP_PAIR:      strobes.selPair = 1'b1;
      default:      ;
    endcase
  end

  generate
    if (REG_OUT) begin : g_regValid
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign validOut = validQ;

      // R8: valid pipeline is exactly one stage
      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> validOut);
      a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !validOut);
    end else begin : g_combValid
      assign validOut = inValid;
    end
  endgenerate

  // At most one mode select is active
  a_r7_one_mode: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selSign, strobes.selZero, strobes.selPair}));

endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  bfxStrobes_t       strobes,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [POS_W-1:0]  fieldPos,
  input  logic [POS_W-1:0]  fieldWidth,
  output logic [DATA_W-1:0] resultNext
);

  localparam int PAIR_W = 2 * DATA_W;

  logic [DATA_W-1:0] shiftedA;
  logic [DATA_W-1:0] fieldMask;
  logic [DATA_W-1:0] fieldBits;
  logic              fillBit;
  logic [DATA_W-1:0] signFilled;
  logic [PAIR_W-1:0] pairShifted;
  logic [DATA_W-1:0] pairWindow;

  // Single-operand path: right shift, then mask to the field length.
  // Bits shifted in from above bit DATA_W-1 are zero, so an overrunning
  // field reads zeros at its top (and fills with zero in sign mode).
  assign shiftedA  = srcA >> fieldPos;
  assign fieldMask = (DATA_W'(1) << fieldWidth) - DATA_W'(1);
  assign fieldBits = shiftedA & fieldMask;

  always_comb begin
    if (fieldWidth == '0) fillBit = 1'b0;
    else                  fillBit = fieldBits[fieldWidth - POS_W'(1)];
  end

  assign signFilled = fieldBits | ({DATA_W{fillBit}} & ~fieldMask);

  // Pair path: one funnel shift of the concatenated operands
  assign pairShifted = {srcA, srcB} >> fieldPos;
  assign pairWindow  = pairShifted[DATA_W-1:0];

  always_comb begin
    resultNext = '0;
    if (strobes.selSign)      resultNext = signFilled;
    else if (strobes.selZero) resultNext = fieldBits;
    else if (strobes.selPair) resultNext = pairWindow;
  end

endmodule

// File: rtl/bitfield_extract.sv
module bitfield_extract
  import bfx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [POS_W-1:0]  fieldPos,
  input  logic [POS_W-1:0]  fieldWidth,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult
);

  bfxStrobes_t       strobes;
  logic [DATA_W-1:0] resultNext;

  bfx_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .strobes  (strobes),
    .validOut (outValid)
  );

  bfx_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes    (strobes),
    .srcA       (srcA),
    .srcB       (srcB),
    .fieldPos   (fieldPos),
    .fieldWidth (fieldWidth),
    .resultNext (resultNext)
  );

  generate
    if (REG_OUT) begin : g_regResult
      logic [DATA_W-1:0] resultQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                resultQ <= '0;
        else if (strobes.capture) resultQ <= resultNext;
      end
      assign outResult = resultQ;

      a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(outResult));
      a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && opSel == 2'b11) |=> (outResult == '0));
      a_r4_zero_width: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !opSel[1] && fieldWidth == '0) |=> (outResult == '0));
      a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && opSel == 2'b01) |=> ((outResult >> $past(fieldWidth)) == '0));
      a_r6_pair_pos0: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && opSel == 2'b10 && fieldPos == '0) |=> (outResult == $past(srcB)));
      a_r5_overrun_no_fill: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && opSel == 2'b00 && fieldWidth != '0 &&
         ({1'b0, fieldPos} + {1'b0, fieldWidth}) > (POS_W+1)'(DATA_W))
        |=> !outResult[DATA_W-1]);
    end else begin : g_combResult
      assign outResult = resultNext;
    end
  endgenerate

endmodule

// File: tb/tb_bitfield_extract.sv
module tb_bitfield_extract;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [1:0]  opSel;
  logic [31:0] srcA, srcB;
  logic [4:0]  fieldPos, fieldWidth;
  logic        outValid;
  logic [31:0] outResult;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  bitfield_extract dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .fieldPos(fieldPos), .fieldWidth(fieldWidth),
    .outValid(outValid), .outResult(outResult)
  );

  // Reference model, bit by bit from the requirements
  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input int p, input int w);
    logic [31:0] r = '0;
    logic        s = 1'b0;
    if (op == 2'b10) begin
      for (int i = 0; i < 32; i++) begin
        int idx = p + i;
        r[i] = (idx < 32) ? b[idx] : a[idx-32];
      end
    end else if (op != 2'b11) begin
      for (int i = 0; i < w; i++)
        if (p + i < 32) r[i] = a[p+i];
      if (w > 0 && p + w - 1 < 32) s = a[p+w-1];
      if (op == 2'b00)
        for (int i = w; i < 32; i++) r[i] = s;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one request at a falling edge, check one cycle later
  task automatic run_one(input string req, input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input int p, input int w);
    logic [31:0] exp;
    exp = model(op, a, b, p, w);
    @(negedge clk);
    inValid = 1'b1; opSel = op; srcA = a; srcB = b;
    fieldPos = 5'(p); fieldWidth = 5'(w);
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {31'b0, outValid}, 32'd1);
    check(req, outResult, exp);
  endtask

  task automatic test_reset();
    rstN = 1'b0; inValid = 1'b0; opSel = 2'b00;
    srcA = 32'hFFFF_FFFF; srcB = 32'hFFFF_FFFF; fieldPos = '0; fieldWidth = 5'd8;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'b0, outValid}, 32'd0);
    check("R1 result in reset", outResult, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", {31'b0, outValid}, 32'd0);
    check("R1 result after reset", outResult, 32'd0);
  endtask

  task automatic test_zero_fill();
    logic [31:0] lfsr = 32'hACE1_1234;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_one("R2 zero-fill", 2'b01, lfsr, 32'h0, (k * 7) % 26, 1 + (k % 6) * 1);
    end
    run_one("R2 zero-fill mid", 2'b01, 32'h8765_4321, 32'h0, 8, 12);
  endtask

  task automatic test_sign_fill();
    run_one("R3 sign negative", 2'b00, 32'h0000_0F00, 32'h0, 8, 4);
    run_one("R3 sign positive", 2'b00, 32'h0000_0700, 32'h0, 8, 4);
    run_one("R3 sign width31", 2'b00, 32'h4000_0000, 32'h0, 0, 31);
    run_one("R3 sign single bit", 2'b00, 32'h0000_0020, 32'h0, 5, 1);
    for (int k = 0; k < 20; k++)
      run_one("R3 sign sweep", 2'b00, 32'hC3A5_96E1 ^ (32'h1 << k), 32'h0, k, 3 + (k % 9));
  endtask

  task automatic test_zero_width();
    run_one("R4 width0 signed", 2'b00, 32'hFFFF_FFFF, 32'h0, 4, 0);
    run_one("R4 width0 unsigned", 2'b01, 32'hFFFF_FFFF, 32'h0, 31, 0);
  endtask

  task automatic test_overrun();
    run_one("R5 overrun unsigned", 2'b01, 32'hF000_0000, 32'h0, 28, 10);
    run_one("R5 overrun signed", 2'b00, 32'hF000_0000, 32'h0, 28, 10);
    run_one("R5 overrun signed far", 2'b00, 32'hFFFF_FFFF, 32'h0, 31, 31);
  endtask

  task automatic test_pair();
    run_one("R6 pair pos0", 2'b10, 32'h1122_3344, 32'h5566_7788, 0, 0);
    run_one("R6 pair pos8", 2'b10, 32'h1122_3344, 32'h5566_7788, 8, 0);
    run_one("R6 pair pos31", 2'b10, 32'hDEAD_BEEF, 32'h8000_0001, 31, 5);
    for (int p = 1; p < 32; p += 5)
      run_one("R6 pair sweep", 2'b10, 32'h0F1E_2D3C, 32'hA5B4_C3D2, p, 0);
  endtask

  task automatic test_reserved();
    run_one("R7 reserved", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 9);
  endtask

  task automatic test_latency_hold();
    logic [31:0] exp;
    exp = model(2'b01, 32'h0000_AB00, 32'h0, 8, 8);
    @(negedge clk);
    inValid = 1'b1; opSel = 2'b01; srcA = 32'h0000_AB00; fieldPos = 5'd8; fieldWidth = 5'd8;
    // Before the edge nothing new is visible yet
    check("R8 valid before edge", {31'b0, outValid}, 32'd0);
    @(negedge clk);
    inValid = 1'b0;
    check("R8 valid after edge", {31'b0, outValid}, 32'd1);
    check("R8 result after edge", outResult, exp);
    // Change data with inValid low: result must hold
    opSel = 2'b00; srcA = 32'hFFFF_FFFF; fieldPos = 5'd0; fieldWidth = 5'd20;
    @(negedge clk);
    check("R8 valid drops", {31'b0, outValid}, 32'd0);
    check("R9 hold idle 1", outResult, exp);
    opSel = 2'b10; srcB = 32'h1234_5678;
    @(negedge clk);
    check("R9 hold idle 2", outResult, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_zero_fill();
    test_sign_fill();
    test_zero_width();
    test_overrun();
    test_pair();
    test_reserved();
    test_latency_hold();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule